// File: doc/BRIEF.md
# PLL Reprogramming Control Sequencer

This block steps a fractional-N PLL control interface through a fixed series of register-level actions. A reprogram request carries a full divider set (integer multiplier, fractional numerator and denominator, reference divider, output divider) and a flag that selects fractional or integer-only operation. The block first takes the PLL out of hardware control, then turns off the output, the power-up bit and the bypass, in that order. It then writes the divider registers, waits a settle time, powers the PLL up and waits a bounded time for lock. The output is turned back on only after lock is seen.

A second request turns on an unpowered PLL through bypass: bypass on, power on, output on, wait for lock, bypass off. A third request only removes power. Every delay is counted in clock cycles, derived from a cycles-per-microsecond parameter. Each sequence ends with a one-cycle done or error pulse. The analog loop is outside the block and appears only as the `lock_i` input.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, hw_sel_o is 1, and out_en_o, pwr_up_o, bypass_o, busy_o, done_o, err_o, all write strobes and all three register words are 0.
- R2: A reprogram request changes the control bits one per cycle: hw_sel_o falls 1 cycle after the start edge, out_en_o 2 cycles after, pwr_up_o 3 cycles after and bypass_o 4 cycles after. Each step leaves the bits not yet reached unchanged.
- R3: The divider word holds the integer multiplier in bits 24:16, the reference divider in bits 15:13 and the output divider in bits 7:0, with all other bits 0. The numerator word holds the numerator in bits 31:2 with bits 1:0 zero. The denominator word holds the denominator in bits 29:0 with bits 31:30 zero.
- R4: div_we_o pulses 5 cycles after the start edge. In fractional mode (frac_i=1), den_we_o pulses at 6 cycles and num_we_o at 7 cycles, once each. In integer mode neither strobe pulses.
- R5: pwr_up_o rises exactly SETTLE_US*CYC_PER_US cycles after the last divider write strobe is visible.
- R6: If lock_i is not sampled high within LOCK_US*CYC_PER_US cycles after power-up, err_o pulses at the end of that window. In that case out_en_o stays 0 and pwr_up_o stays 1.
- R7: In the reprogram flow, out_en_o rises together with the done_o pulse, in the cycle after the first edge at which lock_i is sampled high.
- R8: An enable request while pwr_up_o=1 produces done_o in the next cycle and changes nothing. Otherwise bypass_o, pwr_up_o and out_en_o rise in successive cycles. After lock, bypass_o falls in the cycle after the lock edge, with done_o. On a lock timeout, err_o pulses and all three bits stay 1.
- R9: A disable request clears only pwr_up_o. hw_sel_o, out_en_o and bypass_o keep their values.
- R10: busy_o is 1 from the cycle after an accepted request until the done_o or err_o cycle, and 0 in that cycle.
- R11: A start pulse while busy_o=1 is ignored: no extra register writes, and the latched divider set is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Reprogram request pulse |
| enable_i | input | 1 | Bypass-based enable request |
| disable_i | input | 1 | Power-down request |
| frac_i | input | 1 | 1 selects fractional mode, 0 integer-only |
| mfi_i | input | 9 | Integer multiplier |
| mfn_i | input | 30 | Fractional numerator |
| mfd_i | input | 30 | Fractional denominator |
| rdiv_i | input | 3 | Reference divider |
| odiv_i | input | 8 | Output divider |
| lock_i | input | 1 | PLL lock status |
| hw_sel_o | output | 1 | Hardware-control select |
| out_en_o | output | 1 | PLL output enable |
| pwr_up_o | output | 1 | PLL power-up |
| bypass_o | output | 1 | PLL bypass |
| div_word_o | output | 32 | Divider register value |
| num_word_o | output | 32 | Numerator register value |
| den_word_o | output | 32 | Denominator register value |
| div_we_o | output | 1 | Divider register write strobe |
| num_we_o | output | 1 | Numerator register write strobe |
| den_we_o | output | 1 | Denominator register write strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed pulse |
| err_o | output | 1 | Lock timeout pulse |

## Verification
A state register that skips or repeats a step shows up within one cycle as a control bit falling out of order, or as a write strobe at the wrong offset from the start edge. An off-by-one in the settle or lock counter moves the power-up edge, or the done or error pulse, by a whole cycle, and the bench catches that against times it computes. A wrong field offset shows in the captured register word on the strobe cycle. A lost divider set or a start accepted while busy shows as a second divider write or a changed word before the run ends.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int unsigned MFI_W  = 9;
  localparam int unsigned MFN_W  = 30;
  localparam int unsigned MFD_W  = 30;
  localparam int unsigned RDIV_W = 3;
  localparam int unsigned ODIV_W = 8;
  localparam int unsigned WORD_W = 32;

  localparam int unsigned DIV_MFI_LSB  = 16;
  localparam int unsigned DIV_RDIV_LSB = 13;
  localparam int unsigned DIV_ODIV_LSB = 0;
  localparam int unsigned NUM_LSB      = 2;
  localparam int unsigned DEN_LSB      = 0;

  typedef struct packed {
    logic              frac;
    logic [MFI_W-1:0]  mfi;
    logic [MFN_W-1:0]  mfn;
    logic [MFD_W-1:0]  mfd;
    logic [RDIV_W-1:0] rdiv;
    logic [ODIV_W-1:0] odiv;
  } pll_cfg_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CLR_HW,
    S_CLR_OE,
    S_CLR_PU,
    S_CLR_BYP,
    S_WR_DIV,
    S_WR_DEN,
    S_WR_NUM,
    S_SETTLE,
    S_LOCK_WAIT,
    S_EN_BYP,
    S_EN_PU,
    S_EN_OE,
    S_EN_WAIT,
    S_EN_CLR
  } seq_state_e;
endpackage

// File: rtl/pll_word_pack.sv
module pll_word_pack
  import pll_seq_pkg::*;
(
  input  pll_cfg_t          cfg_i,
  output logic [WORD_W-1:0] div_o,
  output logic [WORD_W-1:0] num_o,
  output logic [WORD_W-1:0] den_o
);
  always_comb begin
    div_o = '0;
    div_o[DIV_MFI_LSB  +: MFI_W]  = cfg_i.mfi;
    div_o[DIV_RDIV_LSB +: RDIV_W] = cfg_i.rdiv;
    div_o[DIV_ODIV_LSB +: ODIV_W] = cfg_i.odiv;
  end

  always_comb begin
    num_o = '0;
    num_o[NUM_LSB +: MFN_W] = cfg_i.mfn;
  end

  always_comb begin
    den_o = '0;
    den_o[DEN_LSB +: MFD_W] = cfg_i.mfd;
  end
endmodule

// File: rtl/pll_delay_cnt.sv
module pll_delay_cnt #(
  parameter int unsigned SHORT_CYC = 20,
  parameter int unsigned LONG_CYC  = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic long_i,
  output logic hit_o
);
  localparam int unsigned MAX_CYC = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] SHORT_END = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_END  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SAT_END   = CW'(MAX_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != SAT_END) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = long_i ? (cnt_q == LONG_END) : (cnt_q == SHORT_END);

  // a window that is still open keeps counting
  p_cnt_moves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !hit_o && cnt_q != SAT_END) |=> (cnt_q != '0));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 4,
  parameter int unsigned SETTLE_US  = 5,
  parameter int unsigned LOCK_US    = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              enable_i,
  input  logic              disable_i,
  input  logic              frac_i,
  input  logic [8:0]        mfi_i,
  input  logic [29:0]       mfn_i,
  input  logic [29:0]       mfd_i,
  input  logic [2:0]        rdiv_i,
  input  logic [7:0]        odiv_i,
  input  logic              lock_i,
  output logic              hw_sel_o,
  output logic              out_en_o,
  output logic              pwr_up_o,
  output logic              bypass_o,
  output logic [31:0]       div_word_o,
  output logic [31:0]       num_word_o,
  output logic [31:0]       den_word_o,
  output logic              div_we_o,
  output logic              num_we_o,
  output logic              den_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int unsigned LOCK_CYC   = LOCK_US * CYC_PER_US;

  seq_state_e state_q, state_d;
  pll_cfg_t   cfg_in, cfg_q;
  logic [WORD_W-1:0] div_w, num_w, den_w;
  logic hit, cnt_clr, cnt_long;

  logic hw_sel_q, out_en_q, pwr_up_q, bypass_q;
  logic div_we_q, num_we_q, den_we_q, done_q, err_q;
  logic [WORD_W-1:0] div_q, num_q, den_q;

  assign cfg_in = '{frac: frac_i, mfi: mfi_i, mfn: mfn_i, mfd: mfd_i,
                    rdiv: rdiv_i, odiv: odiv_i};

  pll_word_pack i_pack (
    .cfg_i (cfg_q),
    .div_o (div_w),
    .num_o (num_w),
    .den_o (den_w)
  );

  assign cnt_long = (state_q == S_LOCK_WAIT) || (state_q == S_EN_WAIT);
  assign cnt_clr  = (state_d != state_q);

  pll_delay_cnt #(
    .SHORT_CYC (SETTLE_CYC),
    .LONG_CYC  (LOCK_CYC)
  ) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .long_i (cnt_long),
    .hit_o  (hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_i)                    state_d = S_CLR_HW;
        else if (enable_i && !pwr_up_q) state_d = S_EN_BYP;
      end
      S_CLR_HW:    state_d = S_CLR_OE;
      S_CLR_OE:    state_d = S_CLR_PU;
      S_CLR_PU:    state_d = S_CLR_BYP;
      S_CLR_BYP:   state_d = S_WR_DIV;
      S_WR_DIV:    state_d = cfg_q.frac ? S_WR_DEN : S_SETTLE;
      S_WR_DEN:    state_d = S_WR_NUM;
      S_WR_NUM:    state_d = S_SETTLE;
      S_SETTLE:    if (hit) state_d = S_LOCK_WAIT;
      S_LOCK_WAIT: if (lock_i || hit) state_d = S_IDLE;
      S_EN_BYP:    state_d = S_EN_PU;
      S_EN_PU:     state_d = S_EN_OE;
      S_EN_OE:     state_d = S_EN_WAIT;
      S_EN_WAIT: begin
        if (lock_i)   state_d = S_EN_CLR;
        else if (hit) state_d = S_IDLE;
      end
      S_EN_CLR:    state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cfg_q    <= '0;
      hw_sel_q <= 1'b1;
      out_en_q <= 1'b0;
      pwr_up_q <= 1'b0;
      bypass_q <= 1'b0;
      div_q    <= '0;
      num_q    <= '0;
      den_q    <= '0;
      div_we_q <= 1'b0;
      num_we_q <= 1'b0;
      den_we_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      div_we_q <= 1'b0;
      num_we_q <= 1'b0;
      den_we_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i)                   cfg_q    <= cfg_in;
          else if (enable_i && pwr_up_q) done_q   <= 1'b1;
          else if (!enable_i && disable_i) pwr_up_q <= 1'b0;
        end
        S_CLR_HW:  hw_sel_q <= 1'b0;
        S_CLR_OE:  out_en_q <= 1'b0;
        S_CLR_PU:  pwr_up_q <= 1'b0;
        S_CLR_BYP: bypass_q <= 1'b0;
        S_WR_DIV: begin
          div_q    <= div_w;
          div_we_q <= 1'b1;
        end
        S_WR_DEN: begin
          den_q    <= den_w;
          den_we_q <= 1'b1;
        end
        S_WR_NUM: begin
          num_q    <= num_w;
          num_we_q <= 1'b1;
        end
        S_SETTLE: if (hit) pwr_up_q <= 1'b1;
        S_LOCK_WAIT: begin
          if (lock_i) begin
            out_en_q <= 1'b1;
            done_q   <= 1'b1;
          end else if (hit) begin
            err_q    <= 1'b1;
          end
        end
        S_EN_BYP:  bypass_q <= 1'b1;
        S_EN_PU:   pwr_up_q <= 1'b1;
        S_EN_OE:   out_en_q <= 1'b1;
        S_EN_WAIT: if (!lock_i && hit) err_q <= 1'b1;
        S_EN_CLR: begin
          bypass_q <= 1'b0;
          done_q   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign hw_sel_o   = hw_sel_q;
  assign out_en_o   = out_en_q;
  assign pwr_up_o   = pwr_up_q;
  assign bypass_o   = bypass_q;
  assign div_word_o = div_q;
  assign num_word_o = num_q;
  assign den_word_o = den_q;
  assign div_we_o   = div_we_q;
  assign num_we_o   = num_we_q;
  assign den_we_o   = den_we_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;

  p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CLR_BYP) |-> (!hw_sel_q && !out_en_q && !pwr_up_q));

  p_frac_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_we_q || den_we_q) |-> cfg_q.frac);

  p_settle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SETTLE && !hit) |=> !pwr_up_q);

  p_timeout_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LOCK_WAIT && !lock_i && hit) |=> (err_q && !out_en_q && pwr_up_q));

  p_oe_after_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LOCK_WAIT && !lock_i) |=> !out_en_q);

  p_skip_powered_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !start_i && enable_i && pwr_up_q) |=>
      (done_q && state_q == S_IDLE && pwr_up_q));

  p_disable_only_pu_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !start_i && !enable_i && disable_i) |=>
      (!pwr_up_q && $stable(out_en_q) && $stable(bypass_q) && $stable(hw_sel_q)));

  p_end_not_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q || err_q) |-> (state_q == S_IDLE));

  p_cfg_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> $stable(cfg_q));
endmodule

// File: tb/test_pll_reprog_seq.sv
module test_pll_reprog_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  CPU  = 2;
  localparam int  SET_N  = 5 * CPU;
  localparam int  LOCK_N = 200 * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, en = 1'b0, dis = 1'b0, frac = 1'b0, lock = 1'b0;
  logic [8:0] mfi = '0;
  logic [29:0] mfn = '0, mfd = '0;
  logic [2:0] rdiv = '0;
  logic [7:0] odiv = '0;
  logic hw_sel, out_en, pwr_up, bypass, div_we, num_we, den_we, busy, done, err;
  logic [31:0] div_word, num_word, den_word;

  int checks = 0;
  int fails = 0;
  int lock_dly = 1;
  int pu_cnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pll_reprog_seq #(.CYC_PER_US(CPU), .SETTLE_US(5), .LOCK_US(200)) i_pll_reprog_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .enable_i(en), .disable_i(dis),
    .frac_i(frac), .mfi_i(mfi), .mfn_i(mfn), .mfd_i(mfd), .rdiv_i(rdiv), .odiv_i(odiv),
    .lock_i(lock), .hw_sel_o(hw_sel), .out_en_o(out_en), .pwr_up_o(pwr_up),
    .bypass_o(bypass), .div_word_o(div_word), .num_word_o(num_word),
    .den_word_o(den_word), .div_we_o(div_we), .num_we_o(num_we), .den_we_o(den_we),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  // lock model: rises lock_dly negedges after power-up is seen
  initial begin
    forever begin
      @(negedge clk);
      if (pwr_up) pu_cnt++;
      else        pu_cnt = 0;
      lock = pwr_up && (pu_cnt >= lock_dly);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_div(input logic [8:0] m, input logic [2:0] r,
                                          input logic [7:0] o);
    return (32'(m) << 16) | (32'(r) << 13) | 32'(o);
  endfunction

  task automatic run_reprog(input logic fr, input int dly, input bit poke);
    logic [8:0] m = 9'($urandom);
    logic [29:0] n = 30'($urandom), d = 30'($urandom);
    logic [2:0] r = 3'($urandom);
    logic [7:0] o = 8'($urandom);
    logic pre_oe, pre_pu, pre_byp;
    int n_div = 0, n_num = 0, n_den = 0, t_div = -1, t_num = -1, t_den = -1;
    int t_pu = -1, t_end = -1, t_w;
    bit got_done = 0, got_err = 0, busy_ok = 1, ord_ok = 1;
    logic [31:0] w_div = '0, w_num = '0, w_den = '0;
    pre_oe = out_en; pre_pu = pwr_up; pre_byp = bypass;
    lock_dly = dly;
    start = 1'b1; frac = fr; mfi = m; mfn = n; mfd = d; rdiv = r; odiv = o;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (t == 0) start = 1'b0;
      if (poke && t == 10) begin
        start = 1'b1; mfi = ~m; odiv = ~o; frac = ~fr;
      end
      if (poke && t == 11) start = 1'b0;
      case (t)
        1: if (!(hw_sel == 0 && out_en == pre_oe && pwr_up == pre_pu)) ord_ok = 0;
        2: if (!(out_en == 0 && pwr_up == pre_pu && bypass == pre_byp)) ord_ok = 0;
        3: if (!(pwr_up == 0 && bypass == pre_byp)) ord_ok = 0;
        4: if (!(bypass == 0)) ord_ok = 0;
        default: ;
      endcase
      if (div_we) begin n_div++; t_div = t; w_div = div_word; end
      if (num_we) begin n_num++; t_num = t; w_num = num_word; end
      if (den_we) begin n_den++; t_den = t; w_den = den_word; end
      if (t > 3 && pwr_up && t_pu < 0) t_pu = t;
      if (done || err) begin
        got_done = done; got_err = err; t_end = t;
        if (busy) busy_ok = 0;
        break;
      end
      if (!busy) busy_ok = 0;
    end
    chk(ord_ok, "R2 control bit order", 0, 1);
    chk(n_div == 1 && t_div == 5 && w_div == exp_div(m, r, o), "R3 divider word",
        w_div, exp_div(m, r, o));
    if (poke) chk(n_div == 1 && w_div == exp_div(m, r, o), "R11 start while busy", n_div, 1);
    if (fr) begin
      chk(n_den == 1 && t_den == 6 && w_den == {2'b00, d}, "R3 R4 denominator", w_den, {2'b00, d});
      chk(n_num == 1 && t_num == 7 && w_num == {n, 2'b00}, "R3 R4 numerator", w_num, {n, 2'b00});
    end else begin
      chk(n_den == 0 && n_num == 0, "R4 integer mode writes", n_den + n_num, 0);
    end
    t_w = fr ? 7 : 5;
    chk(t_pu == t_w + SET_N, "R5 settle delay", t_pu, t_w + SET_N);
    if (dly <= LOCK_N) begin
      chk(got_done && !got_err && t_end == t_pu + dly && out_en, "R7 enable after lock",
          t_end, t_pu + dly);
    end else begin
      chk(got_err && !got_done && t_end == t_pu + LOCK_N && !out_en && pwr_up,
          "R6 lock timeout", t_end, t_pu + LOCK_N);
    end
    chk(busy_ok, "R10 busy window", 0, 1);
    @(negedge clk);
  endtask

  task automatic run_enable(input int dly);
    logic pre_pu = pwr_up, pre_oe = out_en, pre_byp = bypass, pre_hw = hw_sel;
    int e_l, t_end = -1;
    bit ok = 1, got_done = 0, got_err = 0;
    lock_dly = dly;
    en = 1'b1;
    if (pre_pu) begin
      @(negedge clk); en = 1'b0;
      chk(done && !busy && pwr_up && out_en == pre_oe && bypass == pre_byp && hw_sel == pre_hw,
          "R8 enable when powered", done, 1);
      @(negedge clk);
      return;
    end
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (t == 0) en = 1'b0;
      case (t)
        1: if (!(bypass && !pwr_up && out_en == pre_oe)) ok = 0;
        2: if (!(bypass && pwr_up && out_en == pre_oe)) ok = 0;
        3: if (!(bypass && pwr_up && out_en)) ok = 0;
        default: ;
      endcase
      if (done || err) begin got_done = done; got_err = err; t_end = t; break; end
    end
    chk(ok, "R8 enable order", 0, 1);
    e_l = (dly + 2 > 4) ? dly + 2 : 4;
    if (e_l <= 3 + LOCK_N)
      chk(got_done && t_end == e_l + 1 && !bypass && pwr_up && out_en, "R8 enable lock",
          t_end, e_l + 1);
    else
      chk(got_err && t_end == 3 + LOCK_N && bypass && pwr_up && out_en, "R8 enable timeout",
          t_end, 3 + LOCK_N);
    @(negedge clk);
  endtask

  task automatic run_disable();
    logic pre_oe = out_en, pre_byp = bypass, pre_hw = hw_sel;
    dis = 1'b1;
    @(negedge clk); dis = 1'b0;
    chk(!pwr_up && out_en == pre_oe && bypass == pre_byp && hw_sel == pre_hw,
        "R9 disable", {pwr_up, out_en, bypass, hw_sel}, {1'b0, pre_oe, pre_byp, pre_hw});
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(hw_sel && !out_en && !pwr_up && !bypass && !busy && !done && !err && !div_we &&
        !num_we && !den_we && div_word == 0 && num_word == 0 && den_word == 0,
        "R1 reset state", {hw_sel, out_en, pwr_up, bypass, busy}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    run_enable(3);
    run_enable(2);
    run_disable();
    run_enable(LOCK_N + 50);
    run_reprog(1'b1, 5, 1'b0);
    run_reprog(1'b0, 9, 1'b1);
    run_reprog(1'b1, LOCK_N, 1'b0);
    run_reprog(1'b0, LOCK_N + 1, 1'b0);
    run_disable();
    run_reprog(1'b1, 1, 1'b1);
    for (int i = 0; i < 6; i++)
      run_reprog(1'($urandom), 1 + int'($urandom_range(0, 60)), 1'($urandom));
    run_enable(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule